// File: doc/BRIEF.md
# Load/Store Address and Data Formatter

This block takes one single-register memory instruction at a time and works out where the access goes, how wide it is, what the base register should become afterwards, and how the word returned from memory turns into the value for the destination register. The offset comes from one of three sources: a 12-bit zero-extended immediate for the word/byte family, an 8-bit immediate split across two nibbles for the halfword family, or a register value from outside (the shifter sits outside the block).

A request is captured on the clock edge where `req_valid` is high. In the next cycle the block presents the address, size, byte enables, replicated store data and the base write-back value. The memory's read data arrives on `mem_rdata` during that same cycle, and `ld_value` is formed from it combinationally. For this it uses the size, sign mode, low address bits and destination that were captured with the request. Halfword-family encodings that have no meaning are reported on `illegal`, and they produce neither an access nor a write-back.

Top module: `ldst_agu`

## Requirements
- R1: With pre-indexing (`idx_pre`=1) the access address is base plus offset (`up`=1) or base minus offset (`up`=0), and `wb_en` is high one cycle after the request only when `wback`=1, with `wb_value` equal to that address.
- R2: With post-indexing (`idx_pre`=0) the access address is the unmodified base, and `wb_en` is always high with `wb_value` equal to base plus or minus the offset.
- R3: The offset is `reg_off` when `off_reg`=1. Otherwise, for the word/byte family (`hw_form`=0) it is `imm12` zero-extended. For the halfword family (`hw_form`=1) it is `imm12[11:8]` as the high nibble and `imm12[3:0]` as the low nibble.
- R4: `acc_size` encodes 0=byte, 1=halfword, 2=word. The word/byte family uses byte when `bsel`=1 and word otherwise. The halfword family uses halfword when `hsel`=1 and byte otherwise.
- R5: For a store, `acc_be` has bit `addr[1:0]` set for a byte, 4'b0011 or 4'b1100 by `addr[1]` for a halfword, and 4'b1111 for a word. `acc_wdata` repeats the low byte or halfword of `st_data` in every lane. For a load, `acc_be` is 0.
- R6: A byte load zero-extends the byte at `addr[1:0]` of `mem_rdata`. A signed byte load (halfword family, `ssel`=1, `hsel`=0) sign-extends it.
- R7: A word load rotates `mem_rdata` right by 8 times `addr[1:0]`.
- R8: A word load whose destination `dest` is 15 clears bits 1:0 of the rotated value.
- R9: An unsigned halfword load zero-extends the halfword at `addr[1]`. A signed one sign-extends it. At an odd address the unsigned form returns the aligned halfword zero-extended and rotated right by 8, and the signed form returns the addressed byte sign-extended.
- R10: In the halfword family, a store with `ssel`=1 or `hsel`=0, a load with `ssel`=0 and `hsel`=0, or `idx_pre`=0 with `wback`=1 sets `illegal` for one cycle, with `acc_valid` and `wb_en` low.
- R11: After reset, and in a cycle after no request, `acc_valid`, `wb_en` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| hw_form | input | 1 | 1 = halfword/signed family, 0 = word/byte family |
| off_reg | input | 1 | 1 = offset from `reg_off` |
| idx_pre | input | 1 | Pre-index (1) or post-index (0) |
| up | input | 1 | Add (1) or subtract (0) offset |
| wback | input | 1 | Write back in pre-index mode |
| load | input | 1 | 1 = load, 0 = store |
| bsel | input | 1 | Byte size in word/byte family |
| ssel | input | 1 | Signed in halfword family |
| hsel | input | 1 | Halfword in halfword family |
| imm12 | input | 12 | Immediate offset field |
| dest | input | 4 | Destination register index |
| base | input | 32 | Base register value |
| reg_off | input | 32 | Register offset value |
| st_data | input | 32 | Store source value |
| mem_rdata | input | 32 | Data read from memory |
| acc_valid | output | 1 | Access valid |
| acc_write | output | 1 | Access is a store |
| acc_addr | output | 32 | Access address |
| acc_size | output | 2 | Access size |
| acc_be | output | 4 | Store byte enables |
| acc_wdata | output | 32 | Lane-replicated store data |
| wb_en | output | 1 | Base write-back enable |
| wb_value | output | 32 | Base write-back value |
| illegal | output | 1 | Invalid encoding seen |
| ld_value | output | 32 | Formatted load result |

## Verification
The vector table combines pre- and post-indexing with up and down offsets and all three offset sources. A wrong indexing choice or a wrong offset sign shows up as a different address or write-back value. Stores at word, aligned and upper halfword, and high byte addresses separate the enable and lane patterns, and three invalid halfword encodings confirm that both the access and the write-back are suppressed. Directed loads at each low-address value cover rotation, zero- versus sign-extension, the odd-halfword rules and destination 15, where one data word gives a different answer under each rule.

// File: rtl/ldst_agu.sv
module ldst_agu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        hw_form,
  input  logic        off_reg,
  input  logic        idx_pre,
  input  logic        up,
  input  logic        wback,
  input  logic        load,
  input  logic        bsel,
  input  logic        ssel,
  input  logic        hsel,
  input  logic [11:0] imm12,
  input  logic [3:0]  dest,
  input  logic [31:0] base,
  input  logic [31:0] reg_off,
  input  logic [31:0] st_data,
  input  logic [31:0] mem_rdata,
  output logic        acc_valid,
  output logic        acc_write,
  output logic [31:0] acc_addr,
  output logic [1:0]  acc_size,
  output logic [3:0]  acc_be,
  output logic [31:0] acc_wdata,
  output logic        wb_en,
  output logic [31:0] wb_value,
  output logic        illegal,
  output logic [31:0] ld_value
);
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  logic        hw_ok, bad;
  logic [31:0] offset, moved, addr;
  logic [1:0]  size;
  logic [3:0]  be;
  logic [31:0] wdata;

  assign hw_ok  = (load ? (hsel | ssel) : (hsel & ~ssel)) & (idx_pre | ~wback);
  assign bad    = hw_form & ~hw_ok;
  assign offset = off_reg ? reg_off :
                  hw_form ? {24'b0, imm12[11:8], imm12[3:0]} : {20'b0, imm12};
  assign moved  = up ? base + offset : base - offset;
  assign addr   = idx_pre ? moved : base;
  assign size   = hw_form ? (hsel ? SZ_HALF : SZ_BYTE) : (bsel ? SZ_BYTE : SZ_WORD);

  always_comb begin
    case (size)
      SZ_BYTE: begin
        be    = 4'b0001 << addr[1:0];
        wdata = {4{st_data[7:0]}};
      end
      SZ_HALF: begin
        be    = addr[1] ? 4'b1100 : 4'b0011;
        wdata = {2{st_data[15:0]}};
      end
      default: begin
        be    = 4'b1111;
        wdata = st_data;
      end
    endcase
    if (load) be = 4'b0000;
  end

  logic       r_sext, r_pc;
  logic [1:0] r_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      wb_en     <= 1'b0;
      illegal   <= 1'b0;
      acc_write <= 1'b0;
      acc_addr  <= '0;
      acc_size  <= SZ_WORD;
      acc_be    <= '0;
      acc_wdata <= '0;
      wb_value  <= '0;
      r_sext    <= 1'b0;
      r_pc      <= 1'b0;
      r_lo      <= '0;
    end else begin
      acc_valid <= req_valid & ~bad;
      illegal   <= req_valid & bad;
      wb_en     <= req_valid & ~bad & (~idx_pre | wback);
      if (req_valid) begin
        acc_write <= ~load;
        acc_addr  <= addr;
        acc_size  <= size;
        acc_be    <= be;
        acc_wdata <= wdata;
        wb_value  <= moved;
        r_sext    <= hw_form & ssel;
        r_pc      <= (dest == 4'd15);
        r_lo      <= addr[1:0];
      end
    end
  end

  logic [63:0] dbl;
  logic [31:0] rot;
  logic [15:0] hw;
  logic [7:0]  bt;

  assign dbl = {mem_rdata, mem_rdata} >> {r_lo, 3'b000};
  assign rot = dbl[31:0];
  assign bt  = rot[7:0];
  assign hw  = r_lo[1] ? mem_rdata[31:16] : mem_rdata[15:0];

  always_comb begin
    case (acc_size)
      SZ_BYTE: ld_value = r_sext ? {{24{bt[7]}}, bt} : {24'b0, bt};
      SZ_HALF: begin
        if (r_lo[0])
          ld_value = r_sext ? {{24{bt[7]}}, bt} : {hw[7:0], 16'b0, hw[15:8]};
        else
          ld_value = r_sext ? {{16{hw[15]}}, hw} : {16'b0, hw};
      end
      default: ld_value = r_pc ? {rot[31:2], 2'b00} : rot;
    endcase
  end
endmodule

module ldst_agu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        hw_form,
  input logic        idx_pre,
  input logic        wback,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [1:0]  acc_size,
  input logic [3:0]  acc_be,
  input logic        wb_en,
  input logic        illegal
);
  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!acc_valid && !wb_en));
  // R11
  valid_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid || illegal) |-> $past(req_valid));
  // R5
  store_be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |->
      ($countones(acc_be) == (acc_size == 2'd0 ? 1 : acc_size == 2'd1 ? 2 : 4)));
  // R5
  load_be_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |-> (acc_be == 4'b0000));
  // R2
  post_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !idx_pre && !hw_form) |=> wb_en);
  // R1
  pre_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idx_pre && !wback) |=> !wb_en);
  // R4
  size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_size != 2'd3));
endmodule

bind ldst_agu ldst_agu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hw_form(hw_form),
  .idx_pre(idx_pre), .wback(wback), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_size(acc_size), .acc_be(acc_be), .wb_en(wb_en), .illegal(illegal)
);

// File: tb/ldst_agu_tb.sv
module ldst_agu_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, hw_form, off_reg, idx_pre, up, wback, load, bsel, ssel, hsel;
  logic [11:0] imm12;
  logic [3:0]  dest;
  logic [31:0] base, reg_off, st_data, mem_rdata;
  logic        acc_valid, acc_write, wb_en, illegal;
  logic [31:0] acc_addr, acc_wdata, wb_value, ld_value;
  logic [1:0]  acc_size;
  logic [3:0]  acc_be;

  ldst_agu u_dut (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct packed {
    logic [8:0]  ctl;
    logic [11:0] imm;
    logic [31:0] bse;
    logic [31:0] roff;
    logic [31:0] sdat;
    logic [31:0] e_addr;
    logic [1:0]  e_size;
    logic [3:0]  e_be;
    logic [31:0] e_wdat;
    logic        e_wben;
    logic [31:0] e_wbv;
    logic        e_ill;
    logic        e_val;
  } vec_t;

  // ctl = {hw_form, off_reg, idx_pre, up, wback, load, bsel, ssel, hsel}
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{9'b0_0_1_1_1_0_0_0_0, 12'h010, 32'h1000, 32'h0, 32'hAABBCCDD, 32'h1010, 2'd2, 4'b1111, 32'hAABBCCDD, 1'b1, 32'h1010, 1'b0, 1'b1},
    '{9'b0_1_1_0_0_0_1_0_0, 12'h000, 32'h2008, 32'h5, 32'h11223344, 32'h2003, 2'd0, 4'b1000, 32'h44444444, 1'b0, 32'h0, 1'b0, 1'b1},
    '{9'b0_0_0_1_0_0_0_0_0, 12'h0FF, 32'h3000, 32'h0, 32'h12345678, 32'h3000, 2'd2, 4'b1111, 32'h12345678, 1'b1, 32'h30FF, 1'b0, 1'b1},
    '{9'b1_0_1_1_1_0_0_0_1, 12'h304, 32'h4000, 32'h0, 32'h0000BEEF, 32'h4034, 2'd1, 4'b0011, 32'hBEEFBEEF, 1'b1, 32'h4034, 1'b0, 1'b1},
    '{9'b1_1_0_0_0_0_0_0_1, 12'h000, 32'h5002, 32'h10, 32'h1234CAFE, 32'h5002, 2'd1, 4'b1100, 32'hCAFECAFE, 1'b1, 32'h4FF2, 1'b0, 1'b1},
    '{9'b1_0_1_1_0_0_0_1_1, 12'h000, 32'h6000, 32'h0, 32'h0, 32'h0, 2'd0, 4'b0000, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0},
    '{9'b1_0_0_1_1_1_0_0_1, 12'h000, 32'h6000, 32'h0, 32'h0, 32'h0, 2'd0, 4'b0000, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0},
    '{9'b1_0_1_1_0_1_0_0_0, 12'h000, 32'h6000, 32'h0, 32'h0, 32'h0, 2'd0, 4'b0000, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0},
    '{9'b0_0_1_0_1_1_0_0_0, 12'h004, 32'h6000, 32'h0, 32'h0, 32'h5FFC, 2'd2, 4'b0000, 32'h0, 1'b1, 32'h5FFC, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [8:0] ctl, input logic [11:0] imm, input logic [3:0] d,
                       input logic [31:0] b, input logic [31:0] ro, input logic [31:0] sd);
    @(negedge clk);
    {hw_form, off_reg, idx_pre, up, wback, load, bsel, ssel, hsel} = ctl;
    imm12 = imm; dest = d; base = b; reg_off = ro; st_data = sd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ld(input string req, input logic [8:0] ctl, input logic [3:0] d,
                    input logic [31:0] addr, input logic [31:0] rd, input logic [31:0] exp);
    issue(ctl, 12'h000, d, addr, 32'h0, 32'h0);
    mem_rdata = rd;
    #1;
    chk(req, ld_value, exp);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0;
    {hw_form, off_reg, idx_pre, up, wback, load, bsel, ssel, hsel} = '0;
    imm12 = '0; dest = '0; base = '0; reg_off = '0; st_data = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 valid", {31'b0, acc_valid}, 32'h0);
    chk("R11 wb_en", {31'b0, wb_en}, 32'h0);
    chk("R11 illegal", {31'b0, illegal}, 32'h0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R10 vector table
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].ctl, VEC[i].imm, 4'd1, VEC[i].bse, VEC[i].roff, VEC[i].sdat);
      chk("R10 illegal", {31'b0, illegal}, {31'b0, VEC[i].e_ill});
      chk("R10 valid", {31'b0, acc_valid}, {31'b0, VEC[i].e_val});
      chk("R1 R2 wb_en", {31'b0, wb_en}, {31'b0, VEC[i].e_wben});
      if (VEC[i].e_val) begin
        chk("R1 R2 R3 addr", acc_addr, VEC[i].e_addr);
        chk("R4 size", {30'b0, acc_size}, {30'b0, VEC[i].e_size});
        chk("R5 be", {28'b0, acc_be}, {28'b0, VEC[i].e_be});
        if (acc_write) chk("R5 wdata", acc_wdata, VEC[i].e_wdat);
      end
      if (VEC[i].e_wben) chk("R1 R2 wb_value", wb_value, VEC[i].e_wbv);
    end

    // R11 idle cycle after a request
    @(negedge clk);
    chk("R11 idle valid", {31'b0, acc_valid}, 32'h0);
    chk("R11 idle wb_en", {31'b0, wb_en}, 32'h0);

    // R7 word load rotation
    ld("R7 rot0", 9'b0_0_1_1_0_1_0_0_0, 4'd2, 32'h100, 32'h11223344, 32'h11223344);
    ld("R7 rot1", 9'b0_0_1_1_0_1_0_0_0, 4'd2, 32'h101, 32'h11223344, 32'h44112233);
    ld("R7 rot3", 9'b0_0_1_1_0_1_0_0_0, 4'd2, 32'h103, 32'h11223344, 32'h22334411);
    // R8 destination 15
    ld("R8 pc", 9'b0_0_1_1_0_1_0_0_0, 4'd15, 32'h100, 32'h11223347, 32'h11223344);
    ld("R8 notpc", 9'b0_0_1_1_0_1_0_0_0, 4'd14, 32'h100, 32'h11223347, 32'h11223347);
    // R6 byte loads
    ld("R6 ubyte", 9'b0_0_1_1_0_1_1_0_0, 4'd2, 32'h102, 32'h11F23344, 32'h000000F2);
    ld("R6 sbyte", 9'b1_0_1_1_0_1_0_1_0, 4'd2, 32'h102, 32'h11F23344, 32'hFFFFFFF2);
    ld("R6 sbyte pos", 9'b1_0_1_1_0_1_0_1_0, 4'd2, 32'h100, 32'h11F23344, 32'h00000044);
    // R9 halfword loads
    ld("R9 uhalf", 9'b1_0_1_1_0_1_0_0_1, 4'd2, 32'h102, 32'h80011234, 32'h00008001);
    ld("R9 shalf", 9'b1_0_1_1_0_1_0_1_1, 4'd2, 32'h102, 32'h80011234, 32'hFFFF8001);
    ld("R9 uhalf odd", 9'b1_0_1_1_0_1_0_0_1, 4'd2, 32'h101, 32'h0000ABCD, 32'hCD0000AB);
    ld("R9 shalf odd", 9'b1_0_1_1_0_1_0_1_1, 4'd2, 32'h101, 32'h000080CD, 32'hFFFFFF80);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule